// File: doc/BRIEF.md
# Prefixed Instruction Fetch Sequencer

This block fetches one instruction at a time from a 32-bit instruction stream in which an instruction may be preceded by a single 32-bit prefix word. It stays idle until the core signals that the program counter is stable. It then captures the PC and reads the word at that address through a request/acknowledge memory port.

The word that comes back is inspected in the same cycle. If it is not a prefix, it is handed to the decoder as it is. If it is a prefix, the low part of the prefix is kept as the remap payload. The word at the next address is then read and becomes the instruction that the decoder receives.

With the instruction the decoder receives a prefixed flag, the remap payload and the address of the following instruction. That address is four bytes on for a plain instruction and eight bytes on for a prefixed one. The result is held until the decoder accepts it, and the sequencer then returns to idle.

Top module: `pfetch_seq`

## Requirements
- R1: After a synchronous active-high reset, mem_req and out_valid are 0 and insn, is_prefixed, prefix_rm and next_pc are all 0.
- R2: While idle the block makes no memory request until fetch_start is seen; pc_in and fetch_start are ignored at any other time, so the address fetched is the pc_in sampled with fetch_start.
- R3: A read begins at the captured PC. mem_req stays high with a stable mem_addr until mem_ack is seen high at a clock edge, and mem_rdata is taken in that cycle.
- R4: A fetched word counts as a prefix exactly when its bits 31:26 (the primary opcode field, MSB0 bits 0..5) equal 6'd1.
- R5: For a non-prefix first word exactly one read is made. insn is that word, is_prefixed is 0, prefix_rm is 0 and next_pc is PC+4.
- R6: For a prefix first word a second read is made at PC+4 and its word becomes insn, even if it also has the prefix opcode. is_prefixed is 1, prefix_rm is bits 23:0 of the prefix word and next_pc is PC+8.
- R7: out_valid stays high with insn, is_prefixed, prefix_rm and next_pc unchanged until out_ready is seen. In the cycle after that handshake out_valid is 0 and all four outputs read 0.
- R8: Address arithmetic wraps modulo 2^32, so a PC of 0xFFFFFFFC reads its suffix at 0x00000000 and reports next_pc 0x00000004.
- R9: mem_ack while no request is pending has no effect on the state or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_start | input | 1 | PC is stable; start a fetch when idle |
| pc_in | input | 32 | Address of the instruction to fetch |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Memory has read data this cycle |
| mem_rdata | input | 32 | Memory read data |
| out_valid | output | 1 | Instruction ready for the decoder |
| out_ready | input | 1 | Decoder accepts the instruction |
| insn | output | 32 | Instruction word (the suffix when prefixed) |
| is_prefixed | output | 1 | Instruction carried a prefix |
| prefix_rm | output | 24 | Remap payload from the prefix, zero otherwise |
| next_pc | output | 32 | Address of the following instruction |

## Verification
The assertions check four things on every cycle: a pending memory request holds its address until acknowledged, a prefix acknowledgement leads straight into a request one word further on, a plain instruction never shows a non-zero remap payload, and the handed-off outputs stay frozen until accepted and are cleared after acceptance. Other properties need the bench's scenarios. These are the number and addresses of reads per fetch, the correct choice of prefix versus plain for opcodes next to 1, the independence from pc_in changes and stray acknowledgements while busy, and the wrap of the address at the top of memory. The bench checks them against its own model under random memory latency and random decoder back-pressure.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;

    localparam int WORD_W     = 32;
    localparam int OPC_W      = 6;
    localparam int PREFIX_OPC = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_FIRST,
        ST_READ_SECOND,
        ST_HANDOFF
    } fetch_state_e;

    // Convert a big-endian bit number into a little-endian bit index.
    function automatic int msb0_to_lsb(input int pos);
        return WORD_W - 1 - pos;
    endfunction

endpackage

// File: rtl/pfetch_detect.sv
module pfetch_detect
    import pfetch_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              is_prefix
);
    localparam int OPC_TOP = msb0_to_lsb(0);

    logic [OPC_W-1:0] opcode;

    always_comb begin
        opcode    = word[OPC_TOP -: OPC_W];
        is_prefix = (opcode == OPC_W'(PREFIX_OPC));
    end
endmodule

// File: rtl/pfetch_ctrl.sv
module pfetch_ctrl
    import pfetch_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_start,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic              mem_ack,
    input  logic              first_is_prefix,
    input  logic              out_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] pc_q,
    output logic              load_plain,
    output logic              load_prefix,
    output logic              load_suffix,
    output logic              out_valid,
    output logic              release_now
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    fetch_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (fetch_start) begin
                    pc_q    <= pc_in;
                    state_q <= ST_READ_FIRST;
                end
                ST_READ_FIRST: if (mem_ack)
                    state_q <= first_is_prefix ? ST_READ_SECOND : ST_HANDOFF;
                ST_READ_SECOND: if (mem_ack)
                    state_q <= ST_HANDOFF;
                ST_HANDOFF: if (out_ready)
                    state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req     = (state_q == ST_READ_FIRST) || (state_q == ST_READ_SECOND);
        mem_addr    = (state_q == ST_READ_SECOND) ? pc_q + STEP : pc_q;
        load_plain  = (state_q == ST_READ_FIRST) && mem_ack && !first_is_prefix;
        load_prefix = (state_q == ST_READ_FIRST) && mem_ack && first_is_prefix;
        load_suffix = (state_q == ST_READ_SECOND) && mem_ack;
        out_valid   = (state_q == ST_HANDOFF);
        release_now = out_valid && out_ready;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R6
    second_read_chk: assert property (@(posedge clk) disable iff (rst)
        load_prefix |=> (mem_req && mem_addr == $past(mem_addr) + STEP));
endmodule

// File: rtl/pfetch_hold.sv
module pfetch_hold
    import pfetch_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int RM_W       = 24,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic              load_plain,
    input  logic              load_prefix,
    input  logic              load_suffix,
    input  logic              valid,
    input  logic              release_now,
    output logic [WORD_W-1:0] insn,
    output logic              is_prefixed,
    output logic [RM_W-1:0]   prefix_rm,
    output logic [ADDR_W-1:0] next_pc
);
    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_BYTES);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_BYTES);

    always_ff @(posedge clk) begin
        if (rst || release_now) begin
            insn        <= '0;
            is_prefixed <= 1'b0;
            prefix_rm   <= '0;
            next_pc     <= '0;
        end else if (load_plain) begin
            insn        <= word;
            is_prefixed <= 1'b0;
            prefix_rm   <= '0;
            next_pc     <= pc_q + STEP1;
        end else if (load_prefix) begin
            prefix_rm   <= word[RM_W-1:0];
        end else if (load_suffix) begin
            insn        <= word;
            is_prefixed <= 1'b1;
            next_pc     <= pc_q + STEP2;
        end
    end

    // R5
    rm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !is_prefixed) |-> (prefix_rm == '0));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !release_now) |=> (valid && $stable(insn) && $stable(is_prefixed)
                                     && $stable(prefix_rm) && $stable(next_pc)));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        release_now |=> (!valid && insn == '0 && !is_prefixed
                         && prefix_rm == '0 && next_pc == '0));
endmodule

// File: rtl/pfetch_seq.sv
module pfetch_seq
    import pfetch_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int RM_W       = 24,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_start,
    input  logic [ADDR_W-1:0] pc_in,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] insn,
    output logic              is_prefixed,
    output logic [RM_W-1:0]   prefix_rm,
    output logic [ADDR_W-1:0] next_pc
);
    logic              word_is_prefix;
    logic [ADDR_W-1:0] pc_q;
    logic              load_plain;
    logic              load_prefix;
    logic              load_suffix;
    logic              release_now;

    pfetch_detect u_detect (
        .word      (mem_rdata),
        .is_prefix (word_is_prefix)
    );

    pfetch_ctrl #(
        .ADDR_W     (ADDR_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .fetch_start     (fetch_start),
        .pc_in           (pc_in),
        .mem_ack         (mem_ack),
        .first_is_prefix (word_is_prefix),
        .out_ready       (out_ready),
        .mem_req         (mem_req),
        .mem_addr        (mem_addr),
        .pc_q            (pc_q),
        .load_plain      (load_plain),
        .load_prefix     (load_prefix),
        .load_suffix     (load_suffix),
        .out_valid       (out_valid),
        .release_now     (release_now)
    );

    pfetch_hold #(
        .ADDR_W     (ADDR_W),
        .RM_W       (RM_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_hold (
        .clk         (clk),
        .rst         (rst),
        .word        (mem_rdata),
        .pc_q        (pc_q),
        .load_plain  (load_plain),
        .load_prefix (load_prefix),
        .load_suffix (load_suffix),
        .valid       (out_valid),
        .release_now (release_now),
        .insn        (insn),
        .is_prefixed (is_prefixed),
        .prefix_rm   (prefix_rm),
        .next_pc     (next_pc)
    );
endmodule

// File: tb/pfetch_seq_tb.sv
module pfetch_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_start = 1'b0;
    logic [31:0] pc_in = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] insn;
    logic        is_prefixed;
    logic [23:0] prefix_rm;
    logic [31:0] next_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mem [16];
    bit          stray_ack = 0;
    int          nreads = 0;
    logic [31:0] raddr [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    pfetch_seq dut_i (
        .clk(clk), .rst(rst), .fetch_start(fetch_start), .pc_in(pc_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
        .insn(insn), .is_prefixed(is_prefixed), .prefix_rm(prefix_rm),
        .next_pc(next_pc)
    );

    // Memory model with random latency; optional acknowledgements with no request.
    always @(negedge clk) begin
        if (mem_req) begin
            mem_ack   = ($urandom_range(0, 2) != 0);
            mem_rdata = mem_ack ? mem[mem_addr[5:2]] : $urandom;
        end else begin
            mem_ack   = stray_ack && ($urandom_range(0, 1) == 1);
            mem_rdata = $urandom;
        end
    end

    always @(posedge clk) begin
        if (!rst && mem_req && mem_ack) begin
            if (nreads < 4) raddr[nreads] = mem_addr;
            nreads = nreads + 1;
        end
    end

    function automatic bit is_pfx(input logic [31:0] w);
        return w[31:26] == 6'd1;
    endfunction

    function automatic logic [31:0] mk_plain(input logic [31:0] r);
        logic [31:0] w = r;
        if (w[31:26] == 6'd1) w[31:26] = 6'd2;
        return w;
    endfunction

    function automatic logic [31:0] mk_pfx(input logic [31:0] r);
        return {6'd1, r[25:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic fetch_one(input logic [31:0] pc, input logic [31:0] w0,
                             input logic [31:0] w1, input bit noisy);
        bit          pf = is_pfx(w0);
        logic [31:0] exp_insn = pf ? w1 : w0;
        logic [23:0] exp_rm = pf ? w0[23:0] : 24'd0;
        logic [31:0] exp_npc = pc + (pf ? 32'd8 : 32'd4);
        int          wait_cnt = 0;
        mem[pc[5:2]] = w0;
        mem[(pc + 32'd4) >> 2 & 32'hF] = w1;
        nreads = 0;
        stray_ack = noisy;
        @(negedge clk);
        fetch_start = 1'b1;
        pc_in = pc;
        @(negedge clk);
        while (!out_valid && wait_cnt < 200) begin
            // R2: changes on pc_in / fetch_start while busy must be ignored
            fetch_start = noisy ? 1'($urandom_range(0, 1)) : 1'b0;
            pc_in = $urandom;
            @(negedge clk);
            wait_cnt++;
        end
        fetch_start = 1'b0;
        chk(out_valid, "R3 handoff reached", 32'(out_valid), 32'd1);
        chk(raddr[0] == pc, "R2/R3 first read address", raddr[0], pc);
        chk(nreads == (pf ? 2 : 1), "R5/R6 read count", nreads, pf ? 2 : 1);
        if (pf) chk(raddr[1] == pc + 32'd4, "R6 second read address", raddr[1], pc + 32'd4);
        chk(insn == exp_insn, "R5/R6 insn", insn, exp_insn);
        chk(is_prefixed == pf, "R4 is_prefixed", 32'(is_prefixed), 32'(pf));
        chk(prefix_rm == exp_rm, "R5/R6 prefix_rm", 32'(prefix_rm), 32'(exp_rm));
        chk(next_pc == exp_npc, "R8 next_pc", next_pc, exp_npc);
        for (int i = 0; i < int'($urandom_range(0, 3)); i++) begin
            @(negedge clk);
            chk(out_valid && insn == exp_insn && next_pc == exp_npc && prefix_rm == exp_rm,
                "R7 hold while not ready", insn, exp_insn);
            chk(nreads == (pf ? 2 : 1), "R9 stray ack no read", nreads, pf ? 2 : 1);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid && insn == 0 && !is_prefixed && prefix_rm == 0 && next_pc == 0,
            "R7 cleared after handshake", insn, 32'd0);
        chk(!mem_req, "R2 idle no request", 32'(mem_req), 32'd0);
        stray_ack = 0;
    endtask

    initial begin
        repeat (200000 - 10) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        chk(!mem_req && !out_valid && insn == 0 && !is_prefixed && prefix_rm == 0
            && next_pc == 0, "R1 reset state", insn, 32'd0);
        // R2 / R9: idle with stray acks, no request appears
        stray_ack = 1;
        repeat (5) @(negedge clk);
        chk(!mem_req && !out_valid, "R2/R9 idle stays idle", 32'(mem_req), 32'd0);
        stray_ack = 0;

        // Directed corners
        fetch_one(32'h0000_1000, 32'h0000_0000, 32'h1111_1111, 0);      // R4 opcode 0
        fetch_one(32'h0000_1004, 32'h0800_0000, 32'h2222_2222, 0);      // R4 opcode 2
        fetch_one(32'h0000_1008, 32'hFC00_0000, 32'h3333_3333, 0);      // R4 opcode 63
        fetch_one(32'h0000_2000, 32'h07FF_FFFF, 32'h4444_4444, 0);      // R6 rm all ones
        fetch_one(32'h0000_2010, 32'h0400_0000, 32'h0412_3456, 0);      // R6 suffix has prefix opcode
        fetch_one(32'hFFFF_FFFC, 32'h04AB_CDEF, 32'h5555_5555, 0);      // R8 wrap prefixed
        fetch_one(32'hFFFF_FFFC, 32'h1234_5678, 32'h6666_6666, 1);      // R8 wrap plain

        // Random mix
        for (int n = 0; n < 300; n++) begin
            logic [31:0] pc = {$urandom} & 32'hFFFF_FFFC;
            logic [31:0] w0 = ($urandom_range(0, 1) == 1) ? mk_pfx($urandom) : mk_plain($urandom);
            fetch_one(pc, w0, $urandom, 1'($urandom_range(0, 1)));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule